// File: doc/BRIEF.md
# Staggered TFT Strobe Timing Generator

This block produces the five control strobes that a 240x320 portrait TFT panel needs: a per-line latch pulse, a vertical scan start pulse, a horizontal start pulse, an active-low polarity/clear strobe and a reversal signal that alternates every line. Each strobe comes from its own period/width counter. All counters advance only on cycles where the pixel-clock enable is high. Their periods are derived from one line period, which is the pixel clock rate divided by the frame rate and then by the total line count (320 visible plus 9 blanking).

When `run` is raised, a small sequencer releases the counters in a fixed, staggered order. The reversal counter goes first. The line counter follows once the reversal count has passed a threshold. The remaining three counters then start together once the line count reaches its own threshold. This order fixes the phase relationship between the strobes on every start. A done flag marks the point where the last group has been released. Dropping `run` stops every counter at once and returns all strobes to their inactive levels.

Top module: `tft_strobe_gen`

## Requirements
- R1: The line period in enabled cycles is PIX_CLK_HZ / FRAME_RATE / (ACTIVE_LINES + BLANK_LINES), using integer division. With the default parameters this gives 303.
- R2: `line_pulse_o` is high for one enabled count at the start of each line period and low for the rest of the period.
- R3: `vstart_o` is high for VSTART_LINES (default 2) line periods and repeats every (ACTIVE_LINES + BLANK_LINES) line periods.
- R4: `hstart_o` is high for one enabled count at the start of each line period.
- R5: `polclr_n_o` is low for the first ACTIVE_PIXELS + PIXEL_PAD (default 248) counts of each line period and high for the rest. It is high whenever its counter is stopped.
- R6: `reversal_o` is high for the first line period of a two-line period, so it changes level every line.
- R7: A running counter advances only on cycles where `pix_en` is high. While `pix_en` is low, every strobe holds its level.
- R8: On the first clock edge that sees `run` high while the block is idle, only the reversal counter starts, at count 0. `reversal_o` goes high at this point.
- R9: The line counter starts on the edge after a cycle in which the reversal count is above REV_THRESH (default 11). With a constant enable, `line_pulse_o` first rises 14 edges after `run` is first sampled.
- R10: The horizontal start, vertical start and polarity/clear counters start together, on the edge after a cycle in which the line count is at least LINE_THRESH (default 3). `cfg_done_o` rises on that same edge. With a constant enable, this happens on the 18th edge after `run` is first sampled.
- R11: On the first edge that sees `run` low, all five counters stop and clear, every strobe returns to its inactive level and `cfg_done_o` clears. Raising `run` again restarts the full sequence.
- R12: While `rst_n` is low at a clock edge, all strobes go inactive (`polclr_n_o` high, the rest low) and `cfg_done_o` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; counters advance only when it is high |
| run | input | 1 | Start request; low stops all counters |
| line_pulse_o | output | 1 | Per-line latch pulse, active high |
| vstart_o | output | 1 | Vertical scan start pulse, active high |
| hstart_o | output | 1 | Horizontal start pulse, active high |
| polclr_n_o | output | 1 | Polarity/clear strobe, active low |
| reversal_o | output | 1 | Line-alternating reversal signal |
| cfg_done_o | output | 1 | High once all counters have been released |

## Verification
With a constant enable, the bench checks the exact edges at which each counter group is released. This tells an off-by-one in either threshold apart from a correct start. Under a seeded random enable pattern, every strobe is compared against a bench model each cycle. This separates counters that advance only on enabled cycles from counters that count raw clocks, and it checks that the horizontal and vertical strobes keep their phase across many wraps. Directed cases stop the clock enable, drop `run` both during the start sequence and after it, and restart. These cases show whether the stop is immediate and whether a restart repeats the same stagger. A second instance built with the default parameters is used to measure the derived 303-count line period.

// File: rtl/tft_tg_pkg.sv
// Shared types and helpers for the TFT strobe timing generator.
// Assumes integer pixel clock, frame rate and line counts.
package tft_tg_pkg;

    localparam int NUM_STROBES = 5;

    // Channel indices into the counter bank.
    localparam int CH_REV   = 0;
    localparam int CH_LINE  = 1;
    localparam int CH_HST   = 2;
    localparam int CH_VST   = 3;
    localparam int CH_POL   = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REV  = 2'd1,
        SEQ_LINE = 2'd2,
        SEQ_ALL  = 2'd3
    } seq_state_t;

    // Enabled cycles per line: rate / frames / total lines, truncated.
    function automatic int calc_line_clks(input int hz, input int fps, input int lines);
        return (hz / fps) / lines;
    endfunction

endpackage

// File: rtl/tft_pwm_counter.sv
// One period/width strobe counter.
// Counts 0..PERIOD-1 on enabled cycles while en_i is high and stop_i is low.
// The strobe is asserted while count < WIDTH. ACTIVE_LOW inverts the level.
// When the counter is not enabled, the strobe rests at its inactive level.
// Assumes 1 <= WIDTH < PERIOD and PERIOD < 2**CNT_W.
module tft_pwm_counter #(
    parameter int PERIOD     = 16,
    parameter int WIDTH      = 1,
    parameter bit ACTIVE_LOW = 1'b0,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             stop_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             strobe_o
);

    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(WIDTH);

    logic [CNT_W-1:0] cnt_q;

    // Advance the count on enabled ticks, wrap at the period, clear when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (stop_i || !en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
        end
    end

    // Decode the strobe level from the count and the polarity.
    always_comb begin
        if (en_i) strobe_o = (cnt_q < WIDTH_C) ^ ACTIVE_LOW;
        else      strobe_o = ACTIVE_LOW;
    end

    assign cnt_o = cnt_q;

    // The count never leaves its period.
    assert_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_C);

    // A running counter holds while the pixel enable is low.
    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stop_i && !tick_i) |=> $stable(cnt_q));

    // A stop request clears the count on the next edge.
    assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (cnt_q == '0));

endmodule

// File: rtl/tft_start_seq.sv
// Start sequencer: releases the counter groups in a fixed order.
// Idle -> reversal only -> add the line counter -> add the final group.
// Each step is gated on a count threshold of the group that started before it.
// A low run returns the sequencer to idle in one edge.
module tft_start_seq
    import tft_tg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int REV_THRESH  = 11,
    parameter int LINE_THRESH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] rev_cnt_i,
    input  logic [CNT_W-1:0] line_cnt_i,
    output logic             en_rev_o,
    output logic             en_line_o,
    output logic             en_grp_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] REV_T_C  = CNT_W'(REV_THRESH);
    localparam logic [CNT_W-1:0] LINE_T_C = CNT_W'(LINE_THRESH);

    seq_state_t state_q, state_d;

    // Choose the next release step from the current counts.
    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: state_d = SEQ_REV;
                SEQ_REV:  if (rev_cnt_i > REV_T_C)    state_d = SEQ_LINE;
                SEQ_LINE: if (line_cnt_i >= LINE_T_C) state_d = SEQ_ALL;
                SEQ_ALL:  state_d = SEQ_ALL;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    // Register the sequencing step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Decode the per-group enables from the step.
    assign en_rev_o  = (state_q != SEQ_IDLE);
    assign en_line_o = (state_q == SEQ_LINE) || (state_q == SEQ_ALL);
    assign en_grp_o  = (state_q == SEQ_ALL);
    assign done_o    = en_grp_o;

    // The reversal counter starts alone.
    assert_rev_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_rev_o) |-> (!en_line_o && !en_grp_o));

    // The line counter starts only after the reversal count passes its threshold.
    assert_line_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_line_o) |-> ($past(rev_cnt_i) > REV_T_C));

    // The last group starts only after the line count reaches its threshold.
    assert_grp_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_grp_o) |-> ($past(line_cnt_i) >= LINE_T_C));

    // A low run drops everything on the next edge.
    assert_run_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!done_o && !en_rev_o));

endmodule

// File: rtl/tft_strobe_gen.sv
// Top: five strobe counters and their start sequencer.
// Derives the line and frame periods from the clock rate and the panel size.
// Channel 0 is reversal, 1 line pulse, 2 horizontal start, 3 vertical start,
// 4 polarity/clear (active low).
// Assumes ACTIVE_PIXELS + PIXEL_PAD < line period and REV_THRESH < 2 line periods.
module tft_strobe_gen
    import tft_tg_pkg::*;
#(
    parameter int PIX_CLK_HZ    = 6000000,
    parameter int FRAME_RATE    = 60,
    parameter int ACTIVE_LINES  = 320,
    parameter int BLANK_LINES   = 9,
    parameter int ACTIVE_PIXELS = 240,
    parameter int PIXEL_PAD     = 8,
    parameter int VSTART_LINES  = 2,
    parameter int REV_THRESH    = 11,
    parameter int LINE_THRESH   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en,
    input  logic run,
    output logic line_pulse_o,
    output logic vstart_o,
    output logic hstart_o,
    output logic polclr_n_o,
    output logic reversal_o,
    output logic cfg_done_o
);

    localparam int TOTAL_LINES = ACTIVE_LINES + BLANK_LINES;
    localparam int LINE_CLKS   = calc_line_clks(PIX_CLK_HZ, FRAME_RATE, TOTAL_LINES);
    localparam int FRAME_CLKS  = LINE_CLKS * TOTAL_LINES;
    localparam int CNT_W       = $clog2(FRAME_CLKS + 1);

    localparam int CH_PERIOD [NUM_STROBES] =
        '{2 * LINE_CLKS, LINE_CLKS, LINE_CLKS, FRAME_CLKS, LINE_CLKS};
    localparam int CH_WIDTH [NUM_STROBES] =
        '{LINE_CLKS, 1, 1, VSTART_LINES * LINE_CLKS, ACTIVE_PIXELS + PIXEL_PAD};
    localparam bit CH_LOW [NUM_STROBES] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic                   en_rev, en_line, en_grp, seq_done;
    logic [NUM_STROBES-1:0] ch_en;
    logic [NUM_STROBES-1:0] ch_strobe;
    logic [CNT_W-1:0]       ch_cnt [NUM_STROBES];

    // Map the group enables onto the channels.
    always_comb begin
        ch_en          = '0;
        ch_en[CH_REV]  = en_rev;
        ch_en[CH_LINE] = en_line;
        ch_en[CH_HST]  = en_grp;
        ch_en[CH_VST]  = en_grp;
        ch_en[CH_POL]  = en_grp;
    end

    tft_start_seq #(
        .CNT_W       (CNT_W),
        .REV_THRESH  (REV_THRESH),
        .LINE_THRESH (LINE_THRESH)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .rev_cnt_i  (ch_cnt[CH_REV]),
        .line_cnt_i (ch_cnt[CH_LINE]),
        .en_rev_o   (en_rev),
        .en_line_o  (en_line),
        .en_grp_o   (en_grp),
        .done_o     (seq_done)
    );

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_ch
        tft_pwm_counter #(
            .PERIOD     (CH_PERIOD[g]),
            .WIDTH      (CH_WIDTH[g]),
            .ACTIVE_LOW (CH_LOW[g]),
            .CNT_W      (CNT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ch_en[g]),
            .stop_i   (!run),
            .tick_i   (pix_en),
            .cnt_o    (ch_cnt[g]),
            .strobe_o (ch_strobe[g])
        );
    end

    assign reversal_o   = ch_strobe[CH_REV];
    assign line_pulse_o = ch_strobe[CH_LINE];
    assign hstart_o     = ch_strobe[CH_HST];
    assign vstart_o     = ch_strobe[CH_VST];
    assign polclr_n_o   = ch_strobe[CH_POL];
    assign cfg_done_o   = seq_done;

    // Channels released together stay in lockstep.
    assert_grp_lockstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ch_cnt[CH_HST] == ch_cnt[CH_POL]);

    // The vertical count keeps its line phase aligned with the horizontal count.
    assert_vst_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_cnt[CH_VST] % CNT_W'(LINE_CLKS)) == ch_cnt[CH_HST]);

    // Done implies the polarity/clear channel is running.
    assert_done_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done_o |-> ch_en[CH_POL]);

endmodule

// File: tb/tft_strobe_gen_test.sv
module tft_strobe_gen_test;

    localparam int LP      = 16;
    localparam int NLINES  = 9;
    localparam int PIX_HZ  = LP * NLINES * 60;
    localparam int ACT_PIX = 10;
    localparam int PAD     = 2;
    localparam int PER [5] = '{2 * LP, LP, LP, LP * NLINES, LP};
    localparam int WID [5] = '{LP, 1, 1, 2 * LP, ACT_PIX + PAD};
    localparam bit LOW [5] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n, pix_en, run;
    logic line_o, vst_o, hst_o, pol_o, rev_o, done_o;
    logic d_line, d_vst, d_hst, d_pol, d_rev, d_done;

    int ntests = 0;
    int nfail  = 0;
    int cyc    = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    tft_strobe_gen #(
        .PIX_CLK_HZ(PIX_HZ), .FRAME_RATE(60), .ACTIVE_LINES(6), .BLANK_LINES(3),
        .ACTIVE_PIXELS(ACT_PIX), .PIXEL_PAD(PAD), .VSTART_LINES(2),
        .REV_THRESH(11), .LINE_THRESH(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .run(run),
        .line_pulse_o(line_o), .vstart_o(vst_o), .hstart_o(hst_o),
        .polclr_n_o(pol_o), .reversal_o(rev_o), .cfg_done_o(done_o)
    );

    // Default-parameter instance, used only to measure the derived line period.
    tft_strobe_gen dflt (
        .clk(clk), .rst_n(rst_n), .pix_en(1'b1), .run(1'b1),
        .line_pulse_o(d_line), .vstart_o(d_vst), .hstart_o(d_hst),
        .polclr_n_o(d_pol), .reversal_o(d_rev), .cfg_done_o(d_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Bench model state: per channel running flag and count.
    bit mon [5];
    int mcnt [5];
    bit mdone;

    function automatic bit exp_strobe(input int i);
        if (!mon[i]) return LOW[i];
        return (mcnt[i] < WID[i]) ^ LOW[i];
    endfunction

    function automatic bit act_strobe(input int i);
        case (i)
            0: return rev_o;
            1: return line_o;
            2: return hst_o;
            3: return vst_o;
            default: return pol_o;
        endcase
    endfunction

    function automatic string ch_tag(input int i);
        case (i)
            0: return "R6 reversal";
            1: return "R2 line pulse";
            2: return "R4 hstart";
            3: return "R3 vstart";
            default: return "R5 polclr";
        endcase
    endfunction

    // Advance the model per the requirements, then compare away from the edge.
    always @(posedge clk) begin
        bit o_on [5];
        int o_cnt [5];
        cyc++;
        o_on = mon;
        o_cnt = mcnt;
        if (!rst_n || !run) begin
            for (int i = 0; i < 5; i++) begin mon[i] = 0; mcnt[i] = 0; end
            mdone = 0;
        end else begin
            for (int i = 0; i < 5; i++)
                if (o_on[i] && pix_en) mcnt[i] = (o_cnt[i] == PER[i] - 1) ? 0 : o_cnt[i] + 1;
            mon[0] = 1;
            if (o_on[0] && o_cnt[0] > 11) mon[1] = 1;
            if (o_on[1] && o_cnt[1] >= 3) begin mon[2] = 1; mon[3] = 1; mon[4] = 1; end
            mdone = mon[4];
        end
        #5;
        if (cmp_en) begin
            for (int i = 0; i < 5; i++) chk(ch_tag(i), act_strobe(i), exp_strobe(i));
            chk("R10 done", done_o, mdone);
        end
    end

    // Measure the default instance line period (R1).
    int t_rise1 = -1, t_rise2 = -1;
    logic d_prev = 1'b0;
    always @(posedge clk) begin
        #5;
        if (rst_n && d_line && !d_prev) begin
            if (t_rise1 < 0) t_rise1 = cyc;
            else if (t_rise2 < 0) t_rise2 = cyc;
        end
        d_prev = d_line;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic check_idle(input string tag);
        chk({tag, " reversal"}, rev_o, 0);
        chk({tag, " line"}, line_o, 0);
        chk({tag, " hstart"}, hst_o, 0);
        chk({tag, " vstart"}, vst_o, 0);
        chk({tag, " polclr"}, pol_o, 1);
        chk({tag, " done"}, done_o, 0);
    endtask

    initial begin
        logic [4:0] snap;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; run = 1'b0; pix_en = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R12 reset");
        rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk);

        // Start sequence with constant enable: R8, R9, R10 edges.
        pix_en = 1'b1; run = 1'b1;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k == 1)  begin chk("R8 reversal first", rev_o, 1); chk("R8 line idle", line_o, 0); end
            if (k == 13) chk("R9 line not yet", line_o, 0);
            if (k == 14) chk("R9 line starts", line_o, 1);
            if (k == 17) chk("R10 done not yet", done_o, 0);
            if (k == 18) begin chk("R10 done rises", done_o, 1); chk("R10 polclr active", pol_o, 0); end
        end
        repeat (300) @(negedge clk);

        // Random enable pattern.
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            pix_en = ($urandom % 4) != 0;
        end

        // R7: hold enable low; every strobe must freeze.
        pix_en = 1'b0;
        @(negedge clk);
        snap = {pol_o, vst_o, hst_o, line_o, rev_o};
        repeat (30) @(negedge clk);
        chk("R7 strobes frozen", int'({pol_o, vst_o, hst_o, line_o, rev_o}), int'(snap));
        pix_en = 1'b1;
        repeat (5) @(negedge clk);

        // R11: drop run after configuration.
        run = 1'b0;
        @(negedge clk);
        check_idle("R11 stop");
        repeat (5) @(negedge clk);
        check_idle("R11 stays stopped");

        // Drop run in the middle of sequencing, then restart.
        run = 1'b1;
        repeat (8) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check_idle("R11 mid-sequence stop");
        run = 1'b1;
        for (int k = 0; k < 800; k++) begin
            @(negedge clk);
            pix_en = ($urandom % 3) != 0;
            if (($urandom % 300) == 0) run = 1'b0;
            else run = 1'b1;
        end

        // R9: with no enable, the reversal count never passes its threshold.
        run = 1'b0;
        @(negedge clk);
        run = 1'b1; pix_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R9 line held off without enable", line_o, 0);
        chk("R8 reversal running", rev_o, 1);
        chk("R10 done held off", done_o, 0);
        pix_en = 1'b1;
        repeat (400) @(negedge clk);

        // R1: derived default line period.
        chk("R1 default line period", t_rise2 - t_rise1, 303);

        cmp_en = 0;
        @(negedge clk);
        finish_run();
    end

endmodule